// File: doc/BRIEF.md
# Fuzzy accelerator host register interface

This block is the host-facing front end of a fuzzy inference accelerator. A host processor reaches it over a simple strobe-based bus with a 32-bit bidirectional data bus, a 3-bit register address and active-low select, read, write, ready and reset lines. Through six registers the host can load the fuzzified input X and the rule operand ZIN, read back the fuzzy result ZOUT, issue a command, poll a done flag, and clear the controller.

A command write sets two things: the mode, which is model building or inference, and a go bit. When go is set and the controller is idle, a small sequencer walks a rule-row address counter through all rule rows, one row per clock. It presents each row to the arithmetic datapath together with the mode and a start marker on the first row. When the last row has been issued, the sequencer raises done and drops go. The arithmetic itself sits outside this block. The datapath returns its result through a load strobe into the ZOUT register. A write to the clear address has the same effect as the reset pin.

Top module: `fzy_host_regs`

## Requirements
- R1: `bus_rdy_n` is low in the same cycle whenever `bus_sel_n` is low together with `bus_rd_n` or `bus_wr_n`. In every other case it is high, so there are no wait states.
- R2: The design drives `bus_data` only while `bus_sel_n` and `bus_rd_n` are both low and the address is 010 (ZOUT) or 101 (status). In every other case the bus is left undriven.
- R3: Address 000 (X) and address 001 (ZIN) are write-only and appear on `x_q` and `zin_q` after the clock edge that captures them. A write access counts once, on the first clock with write low, however long the strobe is held.
- R4: ZOUT loads `zout_in` on each clock where `zout_we` is high. A read of address 010 returns ZOUT.
- R5: The command register sits at address 100. Bit 0 is the mode (0 = model building, 1 = inference) and appears on `eng_mode`. Bit 1 is go. Both bits are 0 after reset.
- R6: A read of address 101 returns the done flag in bit 0 and zeros in all other bits. Done is 1 after reset. `eng_done` carries the same flag.
- R7: When go is set while the controller is idle, the next cycle starts a pass. `eng_row_vld` is high for exactly 8 consecutive cycles, `eng_row` counts 0 to 7, `eng_start` marks row 0 only, and done is 0 throughout the pass.
- R8: In the cycle after row 7, done is 1 and `eng_row_vld` is low. Go has been cleared, so no second pass follows unless the host issues a new command.
- R9: Command writes that arrive while a pass is running are ignored. This covers both the mode bit and the go bit.
- R10: A write to address 110 clears the command register and the row counter, sets done and returns the controller to idle, even in the middle of a pass.
- R11: Pulling `rst_n` low has the same effect as R10 and also clears X, ZIN and ZOUT. The reset acts at once and is released on a clock edge.
- R12: Writes have no effect when they go to address 010, 101, 011 or 111, or when they are made with `bus_sel_n` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, same effect as clear |
| bus_sel_n | input | 1 | Active-low select from the host address decoder |
| bus_rd_n | input | 1 | Active-low read strobe |
| bus_wr_n | input | 1 | Active-low write strobe |
| bus_addr | input | 3 | Register address |
| bus_data | inout | 32 | Bidirectional host data bus |
| bus_rdy_n | output | 1 | Active-low ready |
| x_q | output | 32 | Registered fuzzy input X |
| zin_q | output | 32 | Registered ZIN operand |
| zout_in | input | 32 | Result word from the datapath |
| zout_we | input | 1 | Load strobe for ZOUT |
| eng_mode | output | 1 | 0 = model building, 1 = inference |
| eng_start | output | 1 | High on the first row of a pass |
| eng_row_vld | output | 1 | A rule row is being issued this cycle |
| eng_row | output | 3 | Current rule-row address |
| eng_done | output | 1 | Done flag |

## Verification
The sequencer is started in three ways, and each start tells apart a different fault. The first is a single-cycle command write in inference mode. The second is a model-mode command hit by a second command while the pass is running, which separates a controller that ignores the late command from one that restarts or changes mode. The third is a command strobe held for longer than a full pass, which exposes a design that takes a held strobe as repeated writes and so runs a second pass. Passes are also cut short by a clear write and by the reset pin, which checks that the counter and done flag return to idle from any row. Writes to read-only and unused addresses, and a write with select high, check that none of these reach X or the command register.

// File: rtl/fzy_pkg.sv
package fzy_pkg;
  // Register addresses on the host bus
  localparam logic [2:0] RA_X    = 3'b000;
  localparam logic [2:0] RA_ZIN  = 3'b001;
  localparam logic [2:0] RA_ZOUT = 3'b010;
  localparam logic [2:0] RA_CMD  = 3'b100;
  localparam logic [2:0] RA_STAT = 3'b101;
  localparam logic [2:0] RA_CLR  = 3'b110;

  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_e;
endpackage

// File: rtl/fzy_rst_sync.sv
module fzy_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/fzy_bus_decode.sv
module fzy_bus_decode #(
  parameter int ADDR_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel_n,
  input  logic                  rd_n,
  input  logic                  wr_n,
  input  logic [ADDR_W-1:0]     addr,
  output logic [2**ADDR_W-1:0]  wr_stb,
  output logic                  rd_zout,
  output logic                  rd_stat,
  output logic                  bus_oe,
  output logic                  rdy_n
);
  import fzy_pkg::*;
  localparam int NREG = 2**ADDR_W;

  logic wr_req, rd_req, wr_q, wr_first;

  assign wr_req   = !sel_n && !wr_n;
  assign rd_req   = !sel_n && !rd_n;
  assign wr_first = wr_req && !wr_q;

  // Remembers whether the write strobe was already seen last cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b0;
    else        wr_q <= wr_req;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_wr
    assign wr_stb[i] = wr_first && (addr == ADDR_W'(i));
  end

  assign rd_zout = rd_req && (addr == RA_ZOUT);
  assign rd_stat = rd_req && (addr == RA_STAT);
  assign bus_oe  = rd_zout || rd_stat;
  assign rdy_n   = !(wr_req || rd_req);
endmodule

// File: rtl/fzy_seq_ctrl.sv
module fzy_seq_ctrl #(
  parameter int ROWS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    go,
  input  logic                    clr,
  output logic                    row_vld,
  output logic                    start,
  output logic [$clog2(ROWS)-1:0] row,
  output logic                    done,
  output logic                    go_clr
);
  import fzy_pkg::*;
  localparam int ROW_W = $clog2(ROWS);
  localparam logic [ROW_W-1:0] LAST = ROW_W'(ROWS - 1);

  seq_state_e       state_q, state_d;
  logic [ROW_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = done_q;
    go_clr  = 1'b0;
    if (clr) begin
      state_d = SEQ_IDLE;
      cnt_d   = '0;
      done_d  = 1'b1;
    end else begin
      case (state_q)
        SEQ_IDLE: if (go) begin
          state_d = SEQ_RUN;
          cnt_d   = '0;
          done_d  = 1'b0;
        end
        SEQ_RUN: if (cnt_q == LAST) begin
          state_d = SEQ_IDLE;
          cnt_d   = '0;
          done_d  = 1'b1;
          go_clr  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
        default: state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign row_vld = (state_q == SEQ_RUN);
  assign start   = row_vld && (cnt_q == '0);
  assign row     = cnt_q;
  assign done    = done_q;
endmodule

// File: rtl/fzy_host_regs.sv
module fzy_host_regs #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int ROWS   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_sel_n,
  input  logic                    bus_rd_n,
  input  logic                    bus_wr_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  inout  wire  [DATA_W-1:0]       bus_data,
  output logic                    bus_rdy_n,
  output logic [DATA_W-1:0]       x_q,
  output logic [DATA_W-1:0]       zin_q,
  input  logic [DATA_W-1:0]       zout_in,
  input  logic                    zout_we,
  output logic                    eng_mode,
  output logic                    eng_start,
  output logic                    eng_row_vld,
  output logic [$clog2(ROWS)-1:0] eng_row,
  output logic                    eng_done
);
  import fzy_pkg::*;
  localparam int NREG = 2**ADDR_W;

  logic              rst_sync_n;
  logic [NREG-1:0]   wr_stb;
  logic              rd_zout, rd_stat, bus_oe;
  logic              cmd_mode_q, cmd_go_q, go_clr, clr_stb, cmd_we;
  logic [DATA_W-1:0] zout_q, rd_data;

  fzy_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  fzy_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_sync_n), .sel_n(bus_sel_n), .rd_n(bus_rd_n),
    .wr_n(bus_wr_n), .addr(bus_addr), .wr_stb(wr_stb), .rd_zout(rd_zout),
    .rd_stat(rd_stat), .bus_oe(bus_oe), .rdy_n(bus_rdy_n)
  );

  fzy_seq_ctrl #(.ROWS(ROWS)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .go(cmd_go_q), .clr(clr_stb),
    .row_vld(eng_row_vld), .start(eng_start), .row(eng_row),
    .done(eng_done), .go_clr(go_clr)
  );

  assign clr_stb = wr_stb[RA_CLR];
  assign cmd_we  = wr_stb[RA_CMD] && !eng_row_vld;

  // Data registers with explicit load enables
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      x_q    <= '0;
      zin_q  <= '0;
      zout_q <= '0;
    end else begin
      if (wr_stb[RA_X])   x_q    <= bus_data;
      if (wr_stb[RA_ZIN]) zin_q  <= bus_data;
      if (zout_we)        zout_q <= zout_in;
    end
  end

  // Command register: clear wins, then end-of-pass, then host write
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cmd_mode_q <= 1'b0;
      cmd_go_q   <= 1'b0;
    end else if (clr_stb) begin
      cmd_mode_q <= 1'b0;
      cmd_go_q   <= 1'b0;
    end else if (go_clr) begin
      cmd_go_q   <= 1'b0;
    end else if (cmd_we) begin
      cmd_mode_q <= bus_data[0];
      cmd_go_q   <= bus_data[1];
    end
  end

  assign eng_mode = cmd_mode_q;
  assign rd_data  = rd_zout ? zout_q : {{(DATA_W-1){1'b0}}, eng_done};
  assign bus_data = bus_oe ? rd_data : {DATA_W{1'bz}};
endmodule

// File: rtl/fzy_host_regs_chk.sv
module fzy_host_regs_chk #(
  parameter int ROWS = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sel_n,
  input logic                    rd_n,
  input logic                    rdy_n,
  input logic                    bus_oe,
  input logic                    clr_stb,
  input logic                    cmd_go,
  input logic                    row_vld,
  input logic                    start,
  input logic [$clog2(ROWS)-1:0] row,
  input logic                    done
);
  localparam int ROW_W = $clog2(ROWS);
  localparam logic [ROW_W-1:0] LAST = ROW_W'(ROWS - 1);

  assert_rdy_on_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !rd_n) |-> !rdy_n);

  assert_drive_only_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (!sel_n && !rd_n));

  assert_row_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (row_vld && row != LAST && !clr_stb) |=> (row_vld && row == ROW_W'($past(row) + 1'b1)));

  assert_first_row_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(row_vld) |-> (start && row == '0));

  assert_busy_not_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    row_vld |-> !done);

  assert_pass_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (row_vld && row == LAST && !clr_stb) |=> (!row_vld && done && !cmd_go));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> (done && !row_vld && !cmd_go && row == '0));
endmodule

bind fzy_host_regs fzy_host_regs_chk #(.ROWS(ROWS)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .sel_n(bus_sel_n), .rd_n(bus_rd_n),
  .rdy_n(bus_rdy_n), .bus_oe(bus_oe), .clr_stb(clr_stb), .cmd_go(cmd_go_q),
  .row_vld(eng_row_vld), .start(eng_start), .row(eng_row), .done(eng_done)
);

// File: tb/fzy_host_regs_tb.sv
`timescale 1ns/100ps
module fzy_host_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [2:0]  addr = 3'b000;
  logic        drv_en = 1'b0;
  logic [31:0] drv_val = '0;
  wire  [31:0] bus_data;
  logic        rdy_n;
  logic [31:0] x_q, zin_q, zout_in = '0;
  logic        zout_we = 1'b0;
  logic        eng_mode, eng_start, eng_row_vld, eng_done;
  logic [2:0]  eng_row;

  int checks = 0, errors = 0, cyc = 0, rows_seen = 0;
  bit cmp_en = 1'b0, finished = 1'b0;

  assign bus_data = drv_en ? drv_val : 32'bz;

  always #2.5 clk = ~clk;

  fzy_host_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel_n(sel_n), .bus_rd_n(rd_n),
    .bus_wr_n(wr_n), .bus_addr(addr), .bus_data(bus_data), .bus_rdy_n(rdy_n),
    .x_q(x_q), .zin_q(zin_q), .zout_in(zout_in), .zout_we(zout_we),
    .eng_mode(eng_mode), .eng_start(eng_start), .eng_row_vld(eng_row_vld),
    .eng_row(eng_row), .eng_done(eng_done)
  );

  // Behavioural reference model
  bit          m_wrq, m_go, m_mode, m_busy, m_done;
  int          m_cnt;
  logic [31:0] m_x, m_zin, m_zout;

  always @(posedge clk) begin
    bit req, first;
    req   = !sel_n && !wr_n;
    first = req && !m_wrq;
    if (!rst_n) begin
      m_wrq <= 0; m_go <= 0; m_mode <= 0; m_busy <= 0; m_done <= 1; m_cnt <= 0;
      m_x <= '0; m_zin <= '0; m_zout <= '0;
    end else begin
      m_wrq <= req;
      if (zout_we) m_zout <= zout_in;
      if (first && addr == 3'd0) m_x   <= drv_val;
      if (first && addr == 3'd1) m_zin <= drv_val;
      if (first && addr == 3'd6) begin
        m_go <= 0; m_mode <= 0; m_busy <= 0; m_done <= 1; m_cnt <= 0;
      end else if (m_busy) begin
        if (m_cnt == 7) begin
          m_busy <= 0; m_done <= 1; m_go <= 0; m_cnt <= 0;
        end else m_cnt <= m_cnt + 1;
      end else begin
        if (m_go) begin m_busy <= 1; m_cnt <= 0; m_done <= 0; end
        if (first && addr == 3'd4) begin m_mode <= drv_val[0]; m_go <= drv_val[1]; end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare with the model on every clock, after the edge has settled
  always @(posedge clk) begin
    #1;
    if (cmp_en) begin
      if (eng_row_vld) rows_seen++;
      chk("R7 row_vld", 32'(eng_row_vld), 32'(m_busy));
      chk("R7 row", 32'(eng_row), 32'(m_cnt));
      chk("R7 start", 32'(eng_start), 32'(m_busy && m_cnt == 0));
      chk("R8 done", 32'(eng_done), 32'(m_done));
      chk("R5 mode", 32'(eng_mode), 32'(m_mode));
      chk("R3 x", x_q, m_x);
      chk("R3 zin", zin_q, m_zin);
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic bus_write(logic [2:0] a, logic [31:0] v, int hold, bit use_sel);
    @(negedge clk);
    sel_n = !use_sel; wr_n = 1'b0; addr = a; drv_en = 1'b1; drv_val = v;
    #1 chk("R1 rdy on write", 32'(rdy_n), 32'(!use_sel));
    repeat (hold) @(negedge clk);
    sel_n = 1'b1; wr_n = 1'b1; drv_en = 1'b0;
  endtask

  task automatic bus_read(logic [2:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    sel_n = 1'b0; rd_n = 1'b0; addr = a;
    #1;
    chk("R1 rdy on read", 32'(rdy_n), 32'd0);
    chk(tag, bus_data, exp);
    sel_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic read_undriven(logic [2:0] a);
    @(negedge clk);
    sel_n = 1'b0; rd_n = 1'b0; addr = a;
    #1;
    checks++;
    if (!(bus_data === 32'bz || bus_data === 32'h0)) begin
      errors++;
      $display("FAIL R2 bus driven at addr %0d actual=%h expected=undriven", a, bus_data);
    end
    sel_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    cmp_en = 1'b1;
    // R11 / R6 / R5: reset state
    chk("R11 rdy idle", 32'(rdy_n), 32'd1);
    bus_read(3'b101, 32'h1, "R6 status after reset");
    chk("R5 mode after reset", 32'(eng_mode), 32'd0);
    // R3 / R4: data registers
    bus_write(3'b000, 32'hA5A5_0F0F, 1, 1'b1);
    bus_write(3'b001, 32'h1234_5678, 1, 1'b1);
    idle(1);
    chk("R3 x loaded", x_q, 32'hA5A5_0F0F);
    chk("R3 zin loaded", zin_q, 32'h1234_5678);
    @(negedge clk); zout_in = 32'hDEAD_BEEF; zout_we = 1'b1;
    @(negedge clk); zout_we = 1'b0; zout_in = 32'h0;
    bus_read(3'b010, 32'hDEAD_BEEF, "R4 zout read");
    read_undriven(3'b000);
    read_undriven(3'b011);
    // R7 / R8: inference pass
    rows_seen = 0;
    bus_write(3'b100, 32'h3, 1, 1'b1);
    idle(2);
    bus_read(3'b101, 32'h0, "R7 status busy");
    idle(12);
    chk("R7 eight rows", 32'(rows_seen), 32'd8);
    bus_read(3'b101, 32'h1, "R8 status done");
    chk("R5 inference mode kept", 32'(eng_mode), 32'd1);
    // R9: model pass with a late command
    rows_seen = 0;
    bus_write(3'b100, 32'h2, 1, 1'b1);
    idle(3);
    bus_write(3'b100, 32'h3, 1, 1'b1);
    chk("R9 mode not changed mid pass", 32'(eng_mode), 32'd0);
    idle(15);
    chk("R9 one pass only", 32'(rows_seen), 32'd8);
    // R3: held command strobe is one write, so one pass
    rows_seen = 0;
    bus_write(3'b100, 32'h3, 14, 1'b1);
    idle(12);
    chk("R3 held strobe single pass", 32'(rows_seen), 32'd8);
    // R10: clear in the middle of a pass
    bus_write(3'b100, 32'h3, 1, 1'b1);
    idle(4);
    bus_write(3'b110, 32'h0, 1, 1'b1);
    idle(1);
    chk("R10 row_vld after clear", 32'(eng_row_vld), 32'd0);
    chk("R10 mode after clear", 32'(eng_mode), 32'd0);
    bus_read(3'b101, 32'h1, "R10 status after clear");
    idle(12);
    // R11: reset in the middle of a pass
    bus_write(3'b100, 32'h3, 1, 1'b1);
    idle(3);
    @(negedge clk); rst_n = 1'b0;
    #1 chk("R11 row_vld in reset", 32'(eng_row_vld), 32'd0);
    chk("R11 done in reset", 32'(eng_done), 32'd1);
    chk("R11 x in reset", x_q, 32'h0);
    idle(2); rst_n = 1'b1; idle(4);
    bus_read(3'b101, 32'h1, "R11 status after reset");
    // R12: writes that must do nothing
    bus_write(3'b000, 32'h0000_00FF, 1, 1'b1);
    bus_write(3'b010, 32'h0000_0003, 1, 1'b1);
    bus_write(3'b101, 32'h0000_0003, 1, 1'b1);
    bus_write(3'b011, 32'h0000_0003, 1, 1'b1);
    bus_write(3'b111, 32'h0000_0003, 1, 1'b1);
    bus_write(3'b000, 32'hFFFF_0000, 1, 1'b0);
    bus_write(3'b100, 32'h0000_0003, 1, 1'b0);
    idle(3);
    chk("R12 x unchanged", x_q, 32'h0000_00FF);
    chk("R12 no pass started", 32'(eng_row_vld), 32'd0);
    bus_read(3'b010, 32'h0, "R12 zout unchanged");
    bus_read(3'b101, 32'h1, "R12 status unchanged");
    idle(2);
    finished = 1'b1;
    summary();
  end
endmodule